// File: doc/BRIEF.md
# Per-Port Event Counter Snapshot Unit

This block keeps one event counter for every (port, counter index) pair. Each counter advances by one on any cycle where its increment input is high. A host reaches the block through a small 16-bit register window. To capture the counters of one port, the host writes a capture command to the operation register. The block then copies that port's counters into a private snapshot buffer and reports busy while the copy runs. After that, the host issues read commands that each pick one captured counter. The chosen 32-bit value comes back split into a high data register and a low data register. The live counters keep counting the whole time, and the captured copy stays unchanged until the next capture.

The sequencer has four named states. ST_IDLE waits for an accepted command. An in-range capture moves it from ST_IDLE to ST_CAPTURE, where it copies one counter per cycle. After the last index, ST_CAPTURE returns to ST_IDLE. An in-range read moves it from ST_IDLE to ST_FETCH, which loads the data registers in one cycle and returns to ST_IDLE. A port or index outside the configured range moves it from ST_IDLE to ST_REJECT, which clears the data registers in one cycle and returns to ST_IDLE. Every operation ends within NUM_CNTRS cycles, so a host that polls busy a small, bounded number of times always sees it finish.

Top module: `stats_snapshot_unit`

## Requirements
- R1: After reset every live counter, every captured value and both data registers are zero, and the operation register reads 0x0000.
- R2: A host write to address 0 with bit 15 set, bits 14:12 = 3'b101 and a port number in bits 4:0 below NUM_PORTS copies the port's counters, one per cycle, into the snapshot buffer. Busy (operation register bit 15) then reads 1 for exactly NUM_CNTRS cycles.
- R3: A host write to address 0 with bit 15 set, bits 14:12 = 3'b100 and a counter index in bits 4:0 below NUM_CNTRS selects that captured counter. Busy reads 1 for exactly one cycle, and after that the value is in the data registers.
- R4: Address 1 returns bits 31:16 of the selected value and address 2 returns bits 15:0. Counters narrower than 32 bits are zero-extended. Both data registers hold their value until the next read or rejected command completes.
- R5: Increments that arrive after a capture do not change the captured values. A later capture of the same port picks up the new counts.
- R6: Bit port*NUM_CNTRS+index of the increment input adds one to that counter on each cycle it is high. Any number of counters may advance in the same cycle.
- R7: With SATURATE=1 a counter that reaches its all-ones value stays there. With SATURATE=0 it wraps to zero.
- R8: A capture with port >= NUM_PORTS, or a read with index >= NUM_CNTRS, holds busy for one cycle and sets both data registers to zero. It leaves the snapshot buffer unchanged.
- R9: The block ignores a write to address 0 in any of three cases: busy is 1, bit 15 is 0, or bits 14:12 hold neither command code. After such a write, busy, the operation register readback and the data registers do not change.
- R10: The operation register reads busy in bit 15 and, in bits 14:0, the bits 14:0 of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inc | input | NUM_PORTS*NUM_CNTRS | One increment strobe per counter, at bit port*NUM_CNTRS+index |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address: 0 operation, 1 data high, 2 data low |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
The bench builds three copies that share one stimulus. The main copy has 32-bit saturating counters, with four ports and eight counters per port. With these settings, port 4 and index 8 still fit the 5-bit field, so the out-of-range path can be reached. The main copy also reaches a non-zero high half after about 65 thousand increments. The other two copies use 4-bit counters, one saturating and one wrapping, so twenty increments drive both limit behaviours within a short run.

// File: rtl/stats_snap_pkg.sv
package stats_snap_pkg;
    localparam int FIELD_W   = 5;
    localparam int OPC_W     = 3;
    localparam int HOST_DW   = 16;
    localparam int VALUE_W   = 32;

    localparam logic [OPC_W-1:0] OPC_CAPTURE = 3'b101;
    localparam logic [OPC_W-1:0] OPC_READ    = 3'b100;

    localparam logic [1:0] ADDR_OP = 2'd0;
    localparam logic [1:0] ADDR_HI = 2'd1;
    localparam logic [1:0] ADDR_LO = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FETCH   = 2'd2,
        ST_REJECT  = 2'd3
    } snap_state_e;
endpackage

// File: rtl/stats_live_bank.sv
module stats_live_bank
    import stats_snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNTRS = 8,
    parameter int CNT_W     = 32,
    parameter bit SATURATE  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_CNTRS-1:0] evt_inc,
    input  logic [FIELD_W-1:0]             rd_port,
    input  logic [FIELD_W-1:0]             rd_idx,
    output logic [CNT_W-1:0]               rd_value
);
    localparam int TOTAL = NUM_PORTS * NUM_CNTRS;

    logic [CNT_W-1:0] cnt_q [TOTAL];

    // The SATURATE parameter picks how a counter behaves at its top value.
    generate
        if (SATURATE) begin : g_sat
            always_ff @(posedge clk) begin
                for (int i = 0; i < TOTAL; i++) begin
                    if (!rst_n) begin
                        cnt_q[i] <= '0;
                    end else if (evt_inc[i] && (cnt_q[i] != {CNT_W{1'b1}})) begin
                        cnt_q[i] <= cnt_q[i] + 1'b1;
                    end
                end
            end
        end else begin : g_wrap
            always_ff @(posedge clk) begin
                for (int i = 0; i < TOTAL; i++) begin
                    if (!rst_n) begin
                        cnt_q[i] <= '0;
                    end else if (evt_inc[i]) begin
                        cnt_q[i] <= cnt_q[i] + 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        int flat;
        flat = int'(rd_port) * NUM_CNTRS + int'(rd_idx);
        rd_value = '0;
        for (int i = 0; i < TOTAL; i++) begin
            if (i == flat) rd_value = cnt_q[i];
        end
    end
endmodule

// File: rtl/stats_snap_buf.sv
module stats_snap_buf
    import stats_snap_pkg::*;
#(
    parameter int NUM_CNTRS = 8,
    parameter int CNT_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] idx,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   rd_data
);
    logic [CNT_W-1:0] snap_q [NUM_CNTRS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CNTRS; i++) begin
            if (!rst_n) begin
                snap_q[i] <= '0;
            end else if (wr_en && (int'(idx) == i)) begin
                snap_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CNTRS; i++) begin
            if (int'(idx) == i) rd_data = snap_q[i];
        end
    end
endmodule

// File: rtl/stats_cmd_fsm.sv
module stats_cmd_fsm
    import stats_snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNTRS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_accept,
    input  logic [OPC_W-1:0]   cmd_opc,
    input  logic [FIELD_W-1:0] cmd_field,
    output snap_state_e        state_o,
    output logic               busy,
    output logic [FIELD_W-1:0] port_sel,
    output logic [FIELD_W-1:0] idx_sel,
    output logic               snap_wr,
    output logic               fetch_load,
    output logic               zero_load
);
    localparam logic [FIELD_W-1:0] LAST_IDX = FIELD_W'(NUM_CNTRS - 1);

    snap_state_e        state_q, state_d;
    logic [FIELD_W-1:0] port_q, port_d;
    logic [FIELD_W-1:0] idx_q, idx_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
            idx_q   <= idx_d;
        end
    end

    // Transition process
    always_comb begin
        state_d = state_q;
        port_d  = port_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_accept) begin
                    if (cmd_opc == OPC_CAPTURE) begin
                        if (int'(cmd_field) < NUM_PORTS) begin
                            state_d = ST_CAPTURE;
                            port_d  = cmd_field;
                            idx_d   = '0;
                        end else begin
                            state_d = ST_REJECT;
                        end
                    end else begin
                        if (int'(cmd_field) < NUM_CNTRS) begin
                            state_d = ST_FETCH;
                            idx_d   = cmd_field;
                        end else begin
                            state_d = ST_REJECT;
                        end
                    end
                end
            end
            ST_CAPTURE: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_FETCH:  state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        busy       = 1'b1;
        snap_wr    = 1'b0;
        fetch_load = 1'b0;
        zero_load  = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy       = 1'b0;
            ST_CAPTURE: snap_wr    = 1'b1;
            ST_FETCH:   fetch_load = 1'b1;
            ST_REJECT:  zero_load  = 1'b1;
            default:    busy       = 1'b0;
        endcase
    end

    assign state_o  = state_q;
    assign port_sel = port_q;
    assign idx_sel  = idx_q;
endmodule

// File: rtl/stats_snapshot_unit.sv
module stats_snapshot_unit
    import stats_snap_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CNTRS = 8,
    parameter int CNT_W     = 32,
    parameter bit SATURATE  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_CNTRS-1:0] evt_inc,
    input  logic                           host_wr,
    input  logic [1:0]                     host_addr,
    input  logic [HOST_DW-1:0]             host_wdata,
    output logic [HOST_DW-1:0]             host_rdata
);
    logic [OPC_W-1:0]   wr_opc;
    logic               cmd_accept;
    snap_state_e        fsm_state;
    logic               busy;
    logic [FIELD_W-1:0] port_sel, idx_sel;
    logic               snap_wr, fetch_load, zero_load;
    logic [CNT_W-1:0]   live_val, snap_val;
    logic [VALUE_W-1:0] snap_ext;
    logic [VALUE_W-1:0] data_q;
    logic [14:0]        cmd_q;

    assign wr_opc     = host_wdata[14:12];
    assign cmd_accept = host_wr && (host_addr == ADDR_OP) && !busy && host_wdata[15]
                        && ((wr_opc == OPC_CAPTURE) || (wr_opc == OPC_READ));

    stats_cmd_fsm #(.NUM_PORTS(NUM_PORTS), .NUM_CNTRS(NUM_CNTRS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (cmd_accept),
        .cmd_opc    (wr_opc),
        .cmd_field  (host_wdata[FIELD_W-1:0]),
        .state_o    (fsm_state),
        .busy       (busy),
        .port_sel   (port_sel),
        .idx_sel    (idx_sel),
        .snap_wr    (snap_wr),
        .fetch_load (fetch_load),
        .zero_load  (zero_load)
    );

    stats_live_bank #(.NUM_PORTS(NUM_PORTS), .NUM_CNTRS(NUM_CNTRS),
                      .CNT_W(CNT_W), .SATURATE(SATURATE)) live_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_inc  (evt_inc),
        .rd_port  (port_sel),
        .rd_idx   (idx_sel),
        .rd_value (live_val)
    );

    stats_snap_buf #(.NUM_CNTRS(NUM_CNTRS), .CNT_W(CNT_W)) snap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (snap_wr),
        .idx     (idx_sel),
        .wr_data (live_val),
        .rd_data (snap_val)
    );

    always_comb begin
        snap_ext = '0;
        snap_ext[CNT_W-1:0] = snap_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (fetch_load)     data_q <= snap_ext;
            else if (zero_load) data_q <= '0;
            if (cmd_accept)     cmd_q  <= host_wdata[14:0];
        end
    end

    always_comb begin
        unique case (host_addr)
            ADDR_OP: host_rdata = {busy, cmd_q};
            ADDR_HI: host_rdata = data_q[31:16];
            ADDR_LO: host_rdata = data_q[15:0];
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/stats_snapshot_chk.sv
module stats_snapshot_chk
    import stats_snap_pkg::*;
#(
    parameter int NUM_CNTRS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [1:0]         host_addr,
    input logic [HOST_DW-1:0] host_wdata,
    input logic               busy,
    input logic [VALUE_W-1:0] data_q,
    input snap_state_e        fsm_state
);
    logic start_try;
    int   busy_run;

    assign start_try = host_wr && (host_addr == ADDR_OP) && host_wdata[15];

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R2: an idle capture request always raises busy on the next cycle
    a_r2_capture_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_try && host_wdata[14:12] == OPC_CAPTURE) |=> busy);

    // R2 / R3: no operation keeps busy longer than one full copy
    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= NUM_CNTRS);

    // R8: a rejected command leaves zero in the data registers
    a_r8_reject_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_REJECT) |=> (data_q == '0));

    // R4 / R9: with nothing started, the data registers hold their value
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_try) |=> $stable(data_q));

    // R9: a write during busy never restarts the sequencer from ST_FETCH
    a_r9_fetch_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FETCH) |=> !busy);
endmodule

bind stats_snapshot_unit stats_snapshot_chk #(.NUM_CNTRS(NUM_CNTRS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .data_q     (data_q),
    .fsm_state  (fsm_state)
);

// File: tb/stats_snapshot_unit_tb_top.sv
module stats_snapshot_unit_tb_top;
    localparam int NP = 4;
    localparam int NC = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP*NC-1:0] evt_inc = '0;
    logic           host_wr = 1'b0;
    logic [1:0]     host_addr = 2'd0;
    logic [15:0]    host_wdata = 16'h0;
    logic [15:0]    rdata, rdata_sat, rdata_wrap;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNTRS(NC), .CNT_W(32), .SATURATE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata));
    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNTRS(NC), .CNT_W(4), .SATURATE(1'b1)) dut_sat (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_sat));
    stats_snapshot_unit #(.NUM_PORTS(NP), .NUM_CNTRS(NC), .CNT_W(4), .SATURATE(1'b0)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_wrap));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Issue one operation-register write and count the cycles busy reads 1.
    task automatic issue(input logic [15:0] word, output int busy_cycles);
        @(negedge clk);
        host_addr = 2'd0; host_wdata = word; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        busy_cycles = 0;
        while (rdata[15] && busy_cycles < 64) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
        host_addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic read_value(output logic [31:0] v);
        logic [15:0] hi, lo;
        read_reg(2'd1, hi);
        read_reg(2'd2, lo);
        v = {hi, lo};
    endtask

    task automatic pulse(input int flat, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            evt_inc[flat] = 1'b1;
        end
        @(negedge clk);
        evt_inc = '0;
    endtask

    task automatic capture_and_read(input int port, input int idx, input int exp_busy_cap,
                                    input string req, output logic [31:0] v);
        int bc;
        issue(16'hDC00 | 16'(port), bc);
        check({req, " capture busy length"}, 32'(bc), 32'(exp_busy_cap));
        issue(16'hCC00 | 16'(idx), bc);
        check({req, " read busy length"}, 32'(bc), 32'd1);
        read_value(v);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        read_reg(2'd0, v); check("R1 op reg after reset", 32'(v), 32'h0);
        read_reg(2'd1, v); check("R1 data hi after reset", 32'(v), 32'h0);
        read_reg(2'd2, v); check("R1 data lo after reset", 32'(v), 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        int bc;
        pulse(2*NC + 0, 3);
        pulse(2*NC + 1, 7);
        pulse(2*NC + 7, 1);
        capture_and_read(2, 1, NC, "R2 R3 R6", v);
        check("R6 port2 idx1 count", v, 32'd7);
        issue(16'hCC00, bc); read_value(v);
        check("R3 port2 idx0 count", v, 32'd3);
        issue(16'hCC07, bc); read_value(v);
        check("R3 port2 idx7 count", v, 32'd1);
    endtask

    task automatic t_frozen;
        logic [31:0] v;
        int bc;
        pulse(2*NC + 1, 5);
        issue(16'hCC01, bc); read_value(v);
        check("R5 captured value frozen", v, 32'd7);
        capture_and_read(2, 1, NC, "R5", v);
        check("R5 recapture picks new count", v, 32'd12);
    endtask

    task automatic t_multi;
        logic [31:0] v;
        int bc;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            evt_inc[0*NC + 3] = 1'b1;
            evt_inc[1*NC + 3] = 1'b1;
        end
        @(negedge clk);
        evt_inc = '0;
        capture_and_read(0, 3, NC, "R6", v);
        check("R6 simultaneous increments port0 idx3", v, 32'd2);
        issue(16'hCC01, bc); read_value(v);
        check("R6 untouched counter stays zero", v, 32'd0);
    endtask

    task automatic t_invalid;
        logic [31:0] v;
        int bc;
        issue(16'hDC04, bc);
        check("R8 bad port busy length", 32'(bc), 32'd1);
        read_value(v);
        check("R8 bad port zero data", v, 32'd0);
        issue(16'hCC03, bc); read_value(v);
        check("R8 buffer unchanged after bad port", v, 32'd2);
        issue(16'hCC08, bc);
        check("R8 bad index busy length", 32'(bc), 32'd1);
        read_value(v);
        check("R8 bad index zero data", v, 32'd0);
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        logic [15:0] op;
        int bc;
        issue(16'hCC03, bc); read_value(v);
        read_reg(2'd0, op);
        check("R10 op readback", 32'(op), 32'h4C03);
        issue(16'h4C01, bc);
        check("R9 bit15 clear gives no busy", 32'(bc), 32'd0);
        read_reg(2'd0, op);
        check("R9 bit15 clear op unchanged", 32'(op), 32'h4C03);
        issue(16'hEC01, bc);
        check("R9 unknown opcode gives no busy", 32'(bc), 32'd0);
        read_value(v);
        check("R9 unknown opcode data unchanged", v, 32'd2);
        // write a read command while a capture is running
        @(negedge clk);
        host_addr = 2'd0; host_wdata = 16'hDC02; host_wr = 1'b1;
        @(negedge clk);
        host_wdata = 16'hCC01;
        @(negedge clk);
        host_wr = 1'b0;
        bc = 0;
        while (rdata[15] && bc < 64) begin bc++; @(negedge clk); end
        check("R9 capture ran full length despite write", 32'(bc + 1), 32'(NC));
        read_reg(2'd0, op);
        check("R9 R10 op shows capture command", 32'(op), 32'h5C02);
        read_value(v);
        check("R9 busy write did not fetch", v, 32'd2);
    endtask

    task automatic t_split;
        logic [31:0] v;
        pulse(3*NC + 5, 65538);
        capture_and_read(3, 5, NC, "R4", v);
        check("R4 high half", 32'(v[31:16]), 32'd1);
        check("R4 low half", 32'(v[15:0]), 32'd2);
    endtask

    task automatic t_limit;
        logic [31:0] v;
        pulse(1*NC + 2, 20);
        capture_and_read(1, 2, NC, "R7", v);
        check("R7 wide counter", v, 32'd20);
        host_addr = 2'd2; #0.5;
        check("R7 saturating 4-bit counter", 32'(rdata_sat), 32'd15);
        check("R7 wrapping 4-bit counter", 32'(rdata_wrap), 32'd4);
        host_addr = 2'd1; #0.5;
        check("R4 R7 narrow counter zero-extended", 32'(rdata_sat), 32'd0);
    endtask

    initial begin
        #(4 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_frozen();
        t_multi();
        t_invalid();
        t_ignored();
        t_split();
        t_limit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule